// File: doc/BRIEF.md
# Serial Constant-Ratio Scaler

This block divides a 24-bit unsigned sample by about 1.122. It does this by multiplying the sample by the integer 7301 and then keeping only the bits above bit 12, which is the same as dividing by 8192. The multiply does not use a parallel multiplier. It runs serially for 13 clock cycles, one cycle per bit of the 13-bit constant. An accumulator adds in a left-shifting copy of the sample on each cycle where the current constant bit is 1.

To use it, pulse the start input for one cycle while the block is idle, with the sample on the data input. The block raises a busy flag and, 13 steps later, gives a one-cycle done pulse. The truncated quotient then appears on the result output and stays there until the next operation finishes. The block runs one operation at a time. A start pulse that arrives mid-operation is dropped.

Top module: `const_ratio_scaler`

## Requirements
- R1: An asynchronous active-high reset sets the result to zero and drives done and busy low, both at once and for as long as reset is held.
- R2: The result of an accepted operation equals floor(sample × 7301 / 8192) for every 24-bit unsigned sample, including 0, 1, 8191 and 0xFFFFFF.
- R3: Suppose start is sampled high at clock edge E0 while the block is idle. Done is then high for exactly one cycle, the cycle after edge E0+13.
- R4: Busy goes high in the cycle after the accepted start edge and stays high for 13 cycles. It is low in the done cycle.
- R5: A start pulse seen while busy is high is ignored. The running operation is not disturbed, its result is unchanged, and no extra done pulse follows.
- R6: The result output changes only on the edge that raises done. It holds its value at all other times.
- R7: The 37-bit accumulator never overflows during the serial multiply.
- R8: A start pulse given in the done cycle is accepted and begins a new operation at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstHi | input | 1 | Asynchronous reset, active high |
| startReq | input | 1 | One-cycle request to begin scaling |
| sampleIn | input | 24 | Unsigned sample, read in the start cycle |
| busyFlag | output | 1 | High while the serial multiply runs |
| donePulse | output | 1 | One-cycle pulse when a result is ready |
| resultOut | output | 24 | Scaled result, floor(sample*7301/8192) |

## Verification
The in-RTL assertions check these rules on every cycle:
- done is a single-cycle pulse and never coincides with busy;
- an accepted start raises busy;
- the step counter stays in range, and keeps advancing even when start arrives while busy;
- the result changes only on the finishing edge;
- the accumulator add never carries out.

The exact arithmetic value, the 14-edge latency, the reset behaviour in the middle of an operation and the back-to-back start can only be shown by the bench's scenarios. The bench compares these against an independent integer model.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  typedef struct packed {
    logic load;    // capture sample, clear accumulator
    logic step;    // one shift-and-add iteration
    logic addBit;  // current constant bit
    logic finish;  // last iteration: publish result
  } scaler_ctl_t;
endpackage

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
  import scaler_pkg::*;
#(
  parameter int K_W   = 13,
  parameter int K_VAL = 7301
) (
  input  logic        clk,
  input  logic        rstHi,
  input  logic        startReq,
  output scaler_ctl_t ctl,
  output logic        busyFlag,
  output logic        donePulse
);
  localparam int CNT_W = $clog2(K_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(K_W - 1);
  localparam logic [K_W-1:0] K_BITS = K_W'(K_VAL);

  logic             busyQ;
  logic             doneQ;
  logic [CNT_W-1:0] stepCnt;
  logic [K_W-1:0]   kShift;
  logic             lastStep;

  assign lastStep   = busyQ && (stepCnt == LAST);
  assign ctl.load   = startReq && !busyQ;
  assign ctl.step   = busyQ;
  assign ctl.addBit = busyQ && kShift[0];
  assign ctl.finish = lastStep;

  always_ff @(posedge clk or posedge rstHi) begin
    if (rstHi) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      stepCnt <= '0;
      kShift  <= '0;
    end else begin
      doneQ <= lastStep;
      if (ctl.load) begin
        busyQ   <= 1'b1;
        stepCnt <= '0;
        kShift  <= K_BITS;
      end else if (busyQ) begin
        kShift  <= kShift >> 1;
        stepCnt <= stepCnt + 1'b1;
        if (lastStep) busyQ <= 1'b0;
      end
    end
  end

  assign busyFlag  = busyQ;
  assign donePulse = doneQ;

  // R3: done lasts a single cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (rstHi)
    doneQ |=> !doneQ);
  // R4: done never overlaps busy
  p_done_idle_r4: assert property (@(posedge clk) disable iff (rstHi)
    doneQ |-> !busyQ);
  // R4: accepted start raises busy
  p_start_busy_r4: assert property (@(posedge clk) disable iff (rstHi)
    (startReq && !busyQ) |=> busyQ);
  // R5: start while busy does not restart the counter
  p_ignore_start_r5: assert property (@(posedge clk) disable iff (rstHi)
    (busyQ && startReq && !lastStep) |=> (busyQ && stepCnt == $past(stepCnt) + 1'b1));
  // R3: counter stays within the step range
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rstHi)
    busyQ |-> (stepCnt <= LAST));
endmodule

// File: rtl/scaler_dpath.sv
module scaler_dpath
  import scaler_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int K_W    = 13
) (
  input  logic              clk,
  input  logic              rstHi,
  input  scaler_ctl_t       ctl,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] resultOut
);
  localparam int ACC_W = DATA_W + K_W;

  logic [ACC_W-1:0]  mcand;
  logic [ACC_W-1:0]  accQ;
  logic [ACC_W:0]    sumWide;
  logic [ACC_W-1:0]  accNext;
  logic [DATA_W-1:0] resQ;

  assign sumWide = {1'b0, accQ} + {1'b0, mcand};
  assign accNext = ctl.addBit ? sumWide[ACC_W-1:0] : accQ;

  always_ff @(posedge clk or posedge rstHi) begin
    if (rstHi) begin
      mcand <= '0;
      accQ  <= '0;
      resQ  <= '0;
    end else begin
      if (ctl.load) begin
        mcand <= ACC_W'(sampleIn);
        accQ  <= '0;
      end else if (ctl.step) begin
        accQ  <= accNext;
        mcand <= mcand << 1;
      end
      if (ctl.finish) resQ <= accNext[ACC_W-1:K_W];
    end
  end

  assign resultOut = resQ;

  // R7: shift-and-add never carries out of the accumulator
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rstHi)
    ctl.addBit |-> !sumWide[ACC_W]);
  // R6: result only moves on the finishing edge
  p_result_hold_r6: assert property (@(posedge clk) disable iff (rstHi)
    !ctl.finish |=> $stable(resQ));
endmodule

// File: rtl/const_ratio_scaler.sv
module const_ratio_scaler
  import scaler_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int K_W    = 13,
  parameter int K_VAL  = 7301
) (
  input  logic              clk,
  input  logic              rstHi,
  input  logic              startReq,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              busyFlag,
  output logic              donePulse,
  output logic [DATA_W-1:0] resultOut
);
  scaler_ctl_t ctl;

  scaler_ctrl #(.K_W(K_W), .K_VAL(K_VAL)) u_ctrl (
    .clk(clk), .rstHi(rstHi), .startReq(startReq), .ctl(ctl),
    .busyFlag(busyFlag), .donePulse(donePulse)
  );

  scaler_dpath #(.DATA_W(DATA_W), .K_W(K_W)) u_dpath (
    .clk(clk), .rstHi(rstHi), .ctl(ctl), .sampleIn(sampleIn),
    .resultOut(resultOut)
  );
endmodule

// File: tb/sim_const_ratio_scaler.sv
module sim_const_ratio_scaler;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h000000, 24'h000001, 24'h001FFF, 24'hFFFFFF,
    24'h000462, 24'h800000, 24'h123456, 24'hAAAAAA
  };

  logic clk = 1'b0;
  logic rstHi = 1'b1;
  logic startReq = 1'b0;
  logic [23:0] sampleIn = '0;
  logic busyFlag, donePulse;
  logic [23:0] resultOut;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  const_ratio_scaler u0 (
    .clk(clk), .rstHi(rstHi), .startReq(startReq), .sampleIn(sampleIn),
    .busyFlag(busyFlag), .donePulse(donePulse), .resultOut(resultOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] refScale(input logic [23:0] s);
    logic [63:0] p;
    p = 64'(s) * 64'd7301;
    return p[36:13];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive start at a negedge; return at the negedge after the accepting edge.
  task automatic startOp(input logic [23:0] s);
    startReq = 1'b1;
    sampleIn = s;
    @(negedge clk);
    startReq = 1'b0;
    sampleIn = ~s;
  endtask

  // Called at negedge after E0; walks edges E1..E13 checking busy/done.
  task automatic runSteps(input logic [23:0] s, input logic poke);
    for (int k = 1; k <= 13; k++) begin
      if (poke && k == 3) begin startReq = 1'b1; sampleIn = 24'h00F00F; end
      if (poke && k == 5) startReq = 1'b0;
      check("R4 busy", 32'(busyFlag), 32'(1));
      check("R3 done early", 32'(donePulse), 32'(0));
      @(negedge clk);
    end
    check("R3 done", 32'(donePulse), 32'(1));
    check("R4 busy low at done", 32'(busyFlag), 32'(0));
    check("R2 result", 32'(resultOut), 32'(refScale(s)));
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] held;
    @(negedge clk);
    // R1: outputs during reset
    check("R1 result", 32'(resultOut), 32'(0));
    check("R1 done", 32'(donePulse), 32'(0));
    check("R1 busy", 32'(busyFlag), 32'(0));
    @(negedge clk);
    rstHi = 1'b0;
    @(negedge clk);

    // R2/R3/R4: vector table
    for (int i = 0; i < NVEC; i++) begin
      startOp(VEC[i]);
      runSteps(VEC[i], 1'b0);
      @(negedge clk);
      check("R3 done one cycle", 32'(donePulse), 32'(0));
    end

    // R2: random samples
    for (int i = 0; i < 20; i++) begin
      logic [23:0] s;
      s = 24'($urandom);
      startOp(s);
      runSteps(s, 1'b0);
      @(negedge clk);
    end

    // R5: start while busy ignored
    startOp(24'h654321);
    runSteps(24'h654321, 1'b1);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R5 no extra done", 32'(donePulse), 32'(0));
      check("R5 stays idle", 32'(busyFlag), 32'(0));
    end
    // R6: result held while idle
    check("R6 result held", 32'(resultOut), 32'(refScale(24'h654321)));

    // R8: back-to-back start in the done cycle
    startOp(24'h0ABCDE);
    for (int k = 1; k <= 13; k++) @(negedge clk);
    check("R8 done", 32'(donePulse), 32'(1));
    startOp(24'hFEDCBA);
    check("R8 accepted busy", 32'(busyFlag), 32'(1));
    check("R8 prev result", 32'(resultOut), 32'(refScale(24'h0ABCDE)));
    runSteps(24'hFEDCBA, 1'b0);

    // R6: result does not move mid-operation
    held = resultOut;
    @(negedge clk);
    startOp(24'h000010);
    for (int k = 1; k <= 12; k++) begin
      check("R6 stable mid-op", 32'(resultOut), 32'(held));
      @(negedge clk);
    end
    // R1: asynchronous reset mid-operation
    startOp(24'h333333);
    @(negedge clk);
    #1 rstHi = 1'b1;
    #1;
    check("R1 async result", 32'(resultOut), 32'(0));
    check("R1 async busy", 32'(busyFlag), 32'(0));
    check("R1 async done", 32'(donePulse), 32'(0));
    @(negedge clk);
    rstHi = 1'b0;
    @(negedge clk);
    startOp(24'h0FFFFF);
    runSteps(24'h0FFFFF, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule